// File: doc/BRIEF.md
# Backlight PWM Generator

A single-channel pulse-width modulator meant to sit behind a small register write port and drive a display backlight pin. A host writes bytes to an 8-bit address space to set a 16-bit period, a 16-bit duty value, an enable bit and a 16-bit auto-off countdown. Both the period and the duty are counted in ticks of an external clock-enable strobe, which is nominally 8 MHz, so one tick is 125 ns. The registers can only be written; there is no read path.

Each 16-bit setting is written in two parts. The high byte goes into a staging register. The low byte write then commits the staged high byte and the new low byte together, and the result takes effect at once. The running counter is not restarted. Only normal polarity is produced: the output is high at the start of each period and goes low when the duty count is reached.

An optional auto-off countdown can turn the output off by itself. It decrements once per millisecond, derived from the tick, while the output is enabled. When it reaches zero it clears the enable bit. Loading it with all ones disarms it.

Top module: `bl_pwm_gen`

## Requirements
- R1: After reset the output is low, the block is disabled, period and duty are 0, and the auto-off value is 0xFFFF (disarmed).
- R2: A write to a high-byte address (period 0xA5, duty 0xA7, auto-off 0xA1) only stages the byte. The active value and the output waveform do not change.
- R3: A write to period-low 0xA4 or duty-low 0xA6 makes {staged high byte, written byte} the active value in the next cycle, without restarting the period counter.
- R4: While enabled, the period counter advances on each cycle with tick_en high, runs 0..period-1 and then wraps to 0. pwm_out is registered and equals (count < duty) one clock later. A period of 0 holds the count at 0.
- R5: A duty greater than or equal to the period gives a constantly high output. A duty of 0 gives a constantly low output.
- R6: Address 0xA3 sets the enable from data bit 0. While disabled, the counter is held at 0 and pwm_out is low. After the enable is set, counting starts from 0.
- R7: If a new period is at or below the current count, the counter wraps to 0 on the next tick.
- R8: A write to 0xA2 loads {staged 0xA1 byte, data} into the auto-off counter and restarts its millisecond prescaler. If the value is not 0xFFFF, the counter decrements every MS_TICKS ticks while enabled. At zero it clears the enable, unless the same cycle writes 0xA3.
- R9: Writes to any address outside 0xA1..0xA7 change nothing.
- R10: While tick_en is low, the period counter and the millisecond prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base strobe, one pulse per PWM tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The bench targets these corner cases:
- A high byte written alone. A design that committed it early would change the waveform before the low byte arrives.
- A period shrunk below the running count. A wrong design would count up to the 16-bit wrap and leave the output high for a long stretch.
- A duty above the period and a duty of zero. A wrong comparator would give a one-tick glitch or a stuck level.
- Unmapped addresses, a gated tick and an auto-off expiry after a short countdown. Off-by-one errors in the prescaler move the switch-off cycle, and a missing disarm check turns the output off when the value is 0xFFFF.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int unsigned VAL_W  = 16;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] A_OFF_HI = 8'hA1;
  localparam logic [7:0] A_OFF_LO = 8'hA2;
  localparam logic [7:0] A_ENABLE = 8'hA3;
  localparam logic [7:0] A_PER_LO = 8'hA4;
  localparam logic [7:0] A_PER_HI = 8'hA5;
  localparam logic [7:0] A_DTY_LO = 8'hA6;
  localparam logic [7:0] A_DTY_HI = 8'hA7;

  localparam logic [VAL_W-1:0] OFF_DISARMED = '1;

  // next value of the period counter: wraps at or past the period
  function automatic logic [VAL_W-1:0] wrap_next(input logic [VAL_W-1:0] c,
                                                 input logic [VAL_W-1:0] p);
    logic [VAL_W:0] inc;
    inc = {1'b0, c} + {{VAL_W{1'b0}}, 1'b1};
    return (inc >= {1'b0, p}) ? '0 : inc[VAL_W-1:0];
  endfunction

  // normal polarity: high while count is below duty
  function automatic logic level_at(input logic [VAL_W-1:0] c,
                                    input logic [VAL_W-1:0] d);
    return c < d;
  endfunction
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             expire,
  output logic             en_q,
  output logic [VAL_W-1:0] per_q,
  output logic [VAL_W-1:0] duty_q,
  output logic             off_load,
  output logic [VAL_W-1:0] off_val
);
  logic [BYTE_W-1:0] per_stage, duty_stage, off_stage;
  logic hit_off_hi, hit_off_lo, hit_en, hit_per_lo, hit_per_hi, hit_dty_lo, hit_dty_hi;

  assign hit_off_hi = wr_en && (wr_addr == A_OFF_HI);
  assign hit_off_lo = wr_en && (wr_addr == A_OFF_LO);
  assign hit_en     = wr_en && (wr_addr == A_ENABLE);
  assign hit_per_lo = wr_en && (wr_addr == A_PER_LO);
  assign hit_per_hi = wr_en && (wr_addr == A_PER_HI);
  assign hit_dty_lo = wr_en && (wr_addr == A_DTY_LO);
  assign hit_dty_hi = wr_en && (wr_addr == A_DTY_HI);

  assign off_load = hit_off_lo;
  assign off_val  = {off_stage, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_stage  <= '0;
      duty_stage <= '0;
      off_stage  <= '1;
      per_q      <= '0;
      duty_q     <= '0;
      en_q       <= 1'b0;
    end else begin
      if (hit_per_hi) per_stage  <= wr_data;
      if (hit_dty_hi) duty_stage <= wr_data;
      if (hit_off_hi) off_stage  <= wr_data;
      if (hit_per_lo) per_q      <= {per_stage, wr_data};
      if (hit_dty_lo) duty_q     <= {duty_stage, wr_data};
      if (expire)     en_q       <= 1'b0;
      if (hit_en)     en_q       <= wr_data[0];
    end
  end

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_per_hi |=> $stable(per_q));
  assert_duty_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_dty_hi |=> $stable(duty_q));
  assert_expire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !hit_en) |=> !en_q);
  assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < A_OFF_HI || wr_addr > A_DTY_HI) && !expire)
      |=> ($stable(per_q) && $stable(duty_q) && $stable(en_q)));
endmodule

// File: rtl/bl_pwm_counter.sv
module bl_pwm_counter
  import bl_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             en,
  input  logic [VAL_W-1:0] per,
  input  logic [VAL_W-1:0] duty,
  output logic             pwm_q
);
  logic [VAL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (!en)          cnt_q <= '0;
      else if (tick_en) cnt_q <= wrap_next(cnt_q, per);
      pwm_q <= en && level_at(cnt_q, duty);
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per != '0 && cnt_q < per) |=> (cnt_q < $past(per)));
  assert_hold_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !pwm_q));
  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick_en) |=> $stable(cnt_q));
endmodule

// File: rtl/bl_pwm_autooff.sv
module bl_pwm_autooff
  import bl_pwm_pkg::*;
#(
  parameter int unsigned MS_TICKS = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             en,
  input  logic             off_load,
  input  logic [VAL_W-1:0] off_val,
  output logic             expire
);
  localparam int unsigned PRE_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_TICKS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [VAL_W-1:0] left_q;
  logic armed, ms_pulse;

  assign armed    = (left_q != OFF_DISARMED);
  assign ms_pulse = tick_en && en && armed && (left_q != '0) && (pre_q == PRE_LAST);
  assign expire   = en && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      left_q <= OFF_DISARMED;
    end else begin
      if (off_load || !(en && armed)) pre_q <= '0;
      else if (tick_en)              pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (off_load)      left_q <= off_val;
      else if (ms_pulse) left_q <= left_q - 1'b1;
    end
  end

  assert_ms_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_pulse && !off_load) |=> (left_q == $past(left_q) - 1'b1));
  assert_disarmed_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !off_load) |=> !armed);
  assert_pre_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !off_load && en && armed) |=> $stable(pre_q));
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
#(
  parameter int unsigned MS_TICKS = 8000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       pwm_out
);
  logic             en_q;
  logic [VAL_W-1:0] per_q, duty_q, off_val;
  logic             off_load, expire;

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire(expire), .en_q(en_q), .per_q(per_q), .duty_q(duty_q),
    .off_load(off_load), .off_val(off_val)
  );

  bl_pwm_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .en(en_q),
    .per(per_q), .duty(duty_q), .pwm_q(pwm_out)
  );

  bl_pwm_autooff #(.MS_TICKS(MS_TICKS)) u_off (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .en(en_q),
    .off_load(off_load), .off_val(off_val), .expire(expire)
  );

  assert_off_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !pwm_out);
  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && per_q != '0 && duty_q >= per_q) |=> pwm_out);
  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |=> !pwm_out);
endmodule

// File: tb/bl_pwm_gen_tb_top.sv
module bl_pwm_gen_tb_top;
  localparam int MS = 10;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic pwm_out;
  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit q_exp[$];

  bl_pwm_gen #(.MS_TICKS(MS)) dut_i (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  // reference model built from the requirements; pushes expected output
  int m_en, m_per, m_duty, m_cnt, m_pwm, m_ao, m_pre, s_per, s_duty, s_ao;
  always @(posedge clk) begin
    int n_pwm, n_cnt, n_pre, n_ao, n_en;
    bit pulse, armed, load;
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_duty = 0; m_cnt = 0; m_pwm = 0;
      m_ao = 'hFFFF; m_pre = 0; s_per = 0; s_duty = 0; s_ao = 'hFF;
    end else begin
      load  = wr_en && wr_addr == 8'hA2;
      armed = m_ao != 'hFFFF;
      n_pwm = (m_en != 0 && m_cnt < m_duty) ? 1 : 0;
      n_cnt = (m_en == 0) ? 0 : (tick_en ? ((m_cnt + 1 >= m_per) ? 0 : m_cnt + 1) : m_cnt);
      pulse = tick_en && m_en != 0 && armed && m_ao != 0 && m_pre == MS - 1;
      n_pre = (load || !(m_en != 0 && armed)) ? 0 : (tick_en ? ((m_pre == MS - 1) ? 0 : m_pre + 1) : m_pre);
      n_ao  = load ? (s_ao * 256 + wr_data) : (pulse ? m_ao - 1 : m_ao);
      n_en  = (m_en != 0 && m_ao == 0) ? 0 : m_en;
      if (wr_en) begin
        case (wr_addr)
          8'hA1: s_ao = wr_data;
          8'hA3: n_en = wr_data[0];
          8'hA4: m_per = s_per * 256 + wr_data;
          8'hA5: s_per = wr_data;
          8'hA6: m_duty = s_duty * 256 + wr_data;
          8'hA7: s_duty = wr_data;
          default: ;
        endcase
      end
      m_pwm = n_pwm; m_cnt = n_cnt; m_pre = n_pre; m_ao = n_ao; m_en = n_en;
    end
    q_exp.push_back(m_pwm[0]);
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    bit e;
    if (q_exp.size() > 0) begin
      e = q_exp.pop_front();
      checks++;
      if (pwm_out !== e) begin
        fails++;
        $display("FAIL %s: pwm_out=%0b expected=%0b at cycle %0d", cur_req, pwm_out, e, cycles);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int n, input int exp, input string tag);
    int h = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (pwm_out) h++; end
    checks++;
    if (h != exp) begin
      fails++;
      $display("FAIL %s: high cycles=%0d expected=%0d", tag, h, exp);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick_en = 1'b1;
    // R1: reset state
    idle(2);
    checks++;
    if (pwm_out !== 1'b0) begin fails++; $display("FAIL R1: pwm_out=%0b expected=0", pwm_out); end
    // R6/R4: period 10, duty 3
    cur_req = "R4";
    wr(8'hA4, 8'd10); wr(8'hA6, 8'd3); wr(8'hA3, 8'h01);
    idle(12);
    count_high(40, 12, "R4");
    // R2: high byte only stages
    cur_req = "R2";
    wr(8'hA5, 8'h01); wr(8'hA7, 8'h02); wr(8'hA1, 8'h00);
    idle(3);
    count_high(20, 6, "R2");
    // R9: unmapped writes
    cur_req = "R9";
    wr(8'hA0, 8'h00); wr(8'hA8, 8'hFF); wr(8'h00, 8'h00); wr(8'hFF, 8'h00);
    idle(3);
    count_high(30, 9, "R9");
    // R3: low byte commits staged high; period 0x0100+... reset stage first
    cur_req = "R3";
    wr(8'hA5, 8'h00); wr(8'hA7, 8'h00); wr(8'hA4, 8'd20); wr(8'hA6, 8'd5);
    idle(25);
    count_high(40, 10, "R3");
    // R5: duty above period, then zero
    cur_req = "R5";
    wr(8'hA6, 8'd25); idle(3);
    count_high(30, 30, "R5");
    wr(8'hA6, 8'd0); idle(3);
    count_high(30, 0, "R5");
    // R7: shrink period below current count
    cur_req = "R7";
    wr(8'hA6, 8'd2); wr(8'hA5, 8'h00); wr(8'hA4, 8'd200);
    idle(60);
    wr(8'hA4, 8'd5); idle(4);
    count_high(50, 20, "R7");
    // R10: gated tick
    cur_req = "R10";
    for (int i = 0; i < 60; i++) begin @(negedge clk); tick_en = (i % 3) == 0; end
    tick_en = 1'b1;
    // R6: disable holds output low, re-enable restarts
    cur_req = "R6";
    wr(8'hA3, 8'h00); idle(3);
    count_high(20, 0, "R6");
    wr(8'hA3, 8'h01); idle(20);
    // R8: auto-off after 3 ms of MS ticks
    cur_req = "R8";
    wr(8'hA1, 8'h00); wr(8'hA2, 8'h03);
    idle(3 * MS + 8);
    count_high(30, 0, "R8");
    // R8: disarm and re-enable, output keeps running
    wr(8'hA1, 8'hFF); wr(8'hA2, 8'hFF); wr(8'hA3, 8'h01);
    idle(5 * MS);
    count_high(50, 20, "R8");
    idle(3);
    finish_run();
  end
endmodule